// File: doc/BRIEF.md
# Frame-Parallel FIR Filter

This block is a fully parallel finite impulse response filter that accepts a frame of `LANES` consecutive samples in one clock cycle and returns a frame of `LANES` filtered samples. Each output lane draws on the current frame and on a history register. The history register holds the last `TAPS-1` samples of earlier accepted frames, so a lane near the start of a frame still sees its correct predecessors across the frame boundary. The tap set is split across the lanes as a bank of parallel multiply-accumulate subfilters, one per output lane.

Coefficients arrive on a parallel port with one value per tap and may be changed on any cycle. A compile-time prototype mask marks which taps can ever be nonzero. Taps that are cleared in the mask get no multiplier at all, and whatever arrives at their coefficient slot is discarded. Sums are kept at full precision. Each sum is then scaled down by a power of two, rounded to nearest and clamped to the output width. The output valid strobe is the input valid strobe delayed by a fixed two cycles. A synchronous active-low reset empties the history and the pipeline.

Top module: `ffir_frame`

## Requirements
- R1: With h'[j] = coeff tap j when PROTO[j] is 1 and 0 otherwise, output lane k of an accepted frame t equals quant(sum over j of h'[j]·x[t·LANES+k−j]). Samples from earlier accepted frames supply the history, and samples before the first accepted frame count as zero. Lane k of in_data is bits [k·DW +: DW], and lane 0 is the earliest sample of the frame. Lane k of out_data is bits [k·OW +: OW]. All values are two's complement.
- R2: out_valid rises exactly two clock cycles after a cycle in which in_valid is 1, and the results of that frame appear on out_data in the same cycle.
- R3: A cycle with in_valid at 0 leaves the sample history untouched and produces no output valid two cycles later, whatever in_data carries.
- R4: The value on the coeff slot of a tap whose PROTO bit is 0 has no effect on any output.
- R5: quant divides the full-precision sum by 2^SHIFT and rounds to nearest, with exact halves rounded toward positive infinity (0.5 → 1, −0.5 → 0, −1.5 → −1).
- R6: A rounded result outside the signed OW-bit range is clamped to 2^(OW−1)−1 or −2^(OW−1).
- R7: Coefficients are sampled in the same cycle as the frame they apply to. A new coefficient set takes effect for every lane of the first frame presented together with it. Coeff tap j is bits [j·CW +: CW].
- R8: While rst_n is 0 at a clock edge, the history, the in-flight frames, out_valid and out_data are all cleared, and any frame offered in that cycle is dropped.
- R9: out_data holds its last value in cycles where out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of all state |
| in_valid | input | 1 | Qualifies the input frame |
| in_data | input | LANES*DW | Input frame, lane 0 earliest |
| coeff | input | TAPS*CW | Coefficient vector, tap j at slot j |
| out_valid | output | 1 | Qualifies the output frame |
| out_data | output | LANES*OW | Filtered frame, lane 0 earliest |

## Verification
A coefficient update and a valid frame can share a cycle, and the filter must then apply the new set to every lane of that frame even though the older lanes still reach into history taken under the old set. The bench provokes this by reloading random coefficients every few cycles during a long run of random frames with irregular gaps. A reference model in the bench holds its own sample history and quantizer, and it judges each output lane against the coefficients current on the frame's own cycle. Reset landing on a cycle with a valid frame and a frame already in flight is provoked the same way, and both must vanish.

// File: rtl/ffir_pkg.sv
// Package: shared width helpers for the frame-parallel FIR filter.
// Assumes TAPS >= 2 and LANES a power of two from 1 to 64.
package ffir_pkg;

    // Full-precision accumulator width: product width plus growth for the tap sum.
    function automatic int acc_width(int dw, int cw, int taps);
        return dw + cw + ((taps > 1) ? $clog2(taps) : 1);
    endfunction

endpackage

// File: rtl/ffir_history.sv
// Module: sample history and window builder.
// Keeps the last TAPS-1 accepted samples, oldest at the low end, and
// concatenates them below the current frame so that window element m is
// the sample m positions after the oldest held one. Updates only on valid.
module ffir_history #(
    parameter int LANES = 4,
    parameter int TAPS  = 8,
    parameter int DW    = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [LANES*DW-1:0]             in_data,
    output logic [(TAPS-1+LANES)*DW-1:0]    window
);
    localparam int HN = TAPS - 1;
    localparam int WN = TAPS - 1 + LANES;

    logic [HN*DW-1:0] hist;

    // Window: current frame above the held history.
    assign window = {in_data, hist};

    // History update: keep the newest TAPS-1 samples of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (in_valid) begin
            hist <= window[WN*DW-1 -: HN*DW];
        end
    end

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(hist)); // R3
    AST_HIST_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (hist == '0)); // R8

endmodule

// File: rtl/ffir_lane.sv
// Module: one output lane's subfilter.
// Receives the TAPS samples this lane needs, oldest first, and forms the
// full-precision tap sum. Taps cleared in PROTO get no multiplier and their
// coefficient and sample inputs are discarded. The sum is registered on en.
module ffir_lane #(
    parameter int                TAPS  = 8,
    parameter int                DW    = 8,
    parameter int                CW    = 8,
    parameter int                AW    = 19,
    parameter logic [TAPS-1:0]   PROTO = '1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [TAPS*DW-1:0]       samples,
    input  logic [TAPS*CW-1:0]       coeff,
    output logic signed [AW-1:0]     acc
);
    localparam int PW = DW + CW;

    logic signed [AW-1:0] prod [TAPS];
    logic signed [AW-1:0] sum;

    for (genvar j = 0; j < TAPS; j++) begin : g_tap
        // Tap j multiplies the sample j positions before the newest one.
        if (PROTO[j]) begin : g_mul
            logic signed [PW-1:0] p;
            assign p = $signed(coeff[j*CW +: CW]) * $signed(samples[(TAPS-1-j)*DW +: DW]);
            assign prod[j] = {{(AW-PW){p[PW-1]}}, p};
        end else begin : g_pruned
            logic unused_tap;
            assign unused_tap = ^{coeff[j*CW +: CW], samples[(TAPS-1-j)*DW +: DW]};
            assign prod[j] = '0;
        end
    end

    // Adder tree: sum every tap product at full precision.
    always_comb begin
        sum = '0;
        for (int j = 0; j < TAPS; j++) begin
            sum = sum + prod[j];
        end
    end

    // Stage register: capture the sum for accepted frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (en) begin
            acc <= sum;
        end
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc)); // R9

endmodule

// File: rtl/ffir_quant.sv
// Module: output quantizer.
// Divides a full-precision sum by 2^SHIFT, rounding to nearest with halves
// toward +inf, then clamps to a signed OW-bit range. Assumes AW+1 > OW.
module ffir_quant #(
    parameter int AW    = 19,
    parameter int OW    = 10,
    parameter int SHIFT = 6
) (
    input  logic signed [AW-1:0] acc,
    output logic signed [OW-1:0] q
);
    localparam int EW = AW + 1;
    localparam logic signed [EW-1:0] HALF = EW'((2 ** SHIFT) / 2);
    localparam logic signed [EW-1:0] QMAX = EW'((2 ** (OW-1)) - 1);
    localparam logic signed [EW-1:0] QMIN = -QMAX - EW'(1);

    logic signed [EW-1:0] biased;
    logic signed [EW-1:0] scaled;

    // Round: add half an output step, then shift arithmetically (floor).
    always_comb begin
        biased = {acc[AW-1], acc} + HALF;
        scaled = biased >>> SHIFT;
    end

    // Saturate to the output range.
    always_comb begin
        if (scaled > QMAX) begin
            q = QMAX[OW-1:0];
        end else if (scaled < QMIN) begin
            q = QMIN[OW-1:0];
        end else begin
            q = scaled[OW-1:0];
        end
    end

endmodule

// File: rtl/ffir_frame.sv
// Module: frame-parallel FIR filter top.
// Accepts LANES samples per valid cycle and returns LANES filtered samples
// two cycles later. Stage 1 holds per-lane full-precision sums, stage 2 the
// rounded and saturated frame. Assumes LANES a power of two from 1 to 64,
// TAPS >= 2, and that PROTO marks the taps that may be nonzero.
module ffir_frame #(
    parameter int                LANES = 4,
    parameter int                TAPS  = 8,
    parameter int                DW    = 8,
    parameter int                CW    = 8,
    parameter int                OW    = 10,
    parameter int                SHIFT = 6,
    parameter logic [TAPS-1:0]   PROTO = 8'b1011_1101
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*DW-1:0]     in_data,
    input  logic [TAPS*CW-1:0]      coeff,
    output logic                    out_valid,
    output logic [LANES*OW-1:0]     out_data
);
    localparam int AW = ffir_pkg::acc_width(DW, CW, TAPS);
    localparam int WN = TAPS - 1 + LANES;

    logic [WN*DW-1:0]       window;
    logic signed [AW-1:0]   acc [LANES];
    logic [LANES*OW-1:0]    qframe;
    logic                   v1;

    ffir_history #(.LANES(LANES), .TAPS(TAPS), .DW(DW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .window   (window)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Lane k sees window elements k .. k+TAPS-1.
        ffir_lane #(.TAPS(TAPS), .DW(DW), .CW(CW), .AW(AW), .PROTO(PROTO)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (in_valid),
            .samples (window[k*DW +: TAPS*DW]),
            .coeff   (coeff),
            .acc     (acc[k])
        );

        ffir_quant #(.AW(AW), .OW(OW), .SHIFT(SHIFT)) u_quant (
            .acc (acc[k]),
            .q   (qframe[k*OW +: OW])
        );
    end

    // Valid pipeline: delayed copy of the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1        <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            v1        <= in_valid;
            out_valid <= v1;
        end
    end

    // Output register: load the quantized frame only for accepted frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (v1) begin
            out_data <= qframe;
        end
    end

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid); // R2
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid); // R3
    AST_RESET_FLUSH: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0)); // R8
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 $stable(out_data)); // R9

endmodule

// File: tb/ffir_frame_test.sv
`timescale 1ns/1ps
module ffir_frame_test;
    localparam int P  = 4;
    localparam int L  = 8;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int OW = 10;
    localparam int SH = 6;
    localparam logic [L-1:0] PR = 8'b1011_1101;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [P*DW-1:0] in_data = '0;
    logic [L*CW-1:0] coeff = '0;
    logic            out_valid;
    logic [P*OW-1:0] out_data;

    always #2 clk = ~clk;

    ffir_frame #(.LANES(P), .TAPS(L), .DW(DW), .CW(CW), .OW(OW), .SHIFT(SH), .PROTO(PR)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .coeff(coeff), .out_valid(out_valid), .out_data(out_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int coef [L];
    int smp [P];
    int hx [L-1];
    bit p1v = 0, p2v = 0, p1r = 1, p2r = 1;
    int p1d [P];
    int p2d [P];
    int held [P];
    string req = "R8";
    int unsigned seed = 32'h1234_5678;

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed >> 8;
    endfunction

    function automatic int quant(longint s);
        longint r;
        r = (s + (64'sd1 <<< (SH - 1))) >>> SH;
        if (r > (2 ** (OW - 1)) - 1) r = (2 ** (OW - 1)) - 1;
        if (r < -(2 ** (OW - 1))) r = -(2 ** (OW - 1));
        return int'(r);
    endfunction

    function automatic int win(int m);
        return (m < L - 1) ? hx[m] : smp[m - (L - 1)];
    endfunction

    task automatic step(bit rst, bit v);
        int nh [L-1];
        longint s;
        @(negedge clk);
        // check outputs against the entry two cycles old
        n_chk++;
        if (out_valid !== (p2r ? 1'b0 : p2v)) begin
            n_fail++;
            $display("FAIL %s out_valid got %0b exp %0b", req, out_valid, p2r ? 1'b0 : p2v);
        end
        for (int k = 0; k < P; k++) begin
            if (p2r) held[k] = 0;
            else if (p2v) held[k] = p2d[k];
            n_chk++;
            if ($signed(out_data[k*OW +: OW]) != held[k]) begin
                n_fail++;
                $display("FAIL %s lane %0d got %0d exp %0d", req, k,
                         $signed(out_data[k*OW +: OW]), held[k]);
            end
        end
        // drive the next cycle
        rst_n = rst;
        in_valid = v;
        for (int k = 0; k < P; k++) in_data[k*DW +: DW] = smp[k][DW-1:0];
        for (int j = 0; j < L; j++) coeff[j*CW +: CW] = coef[j][CW-1:0];
        if (!rst) begin
            for (int m = 0; m < L - 1; m++) hx[m] = 0;
            p1v = 0; p2v = 0; p1r = 1; p2r = 1;
        end else begin
            p2v = p1v; p2r = p1r; p2d = p1d;
            p1v = v; p1r = 0;
            if (v) begin
                for (int k = 0; k < P; k++) begin
                    s = 0;
                    for (int j = 0; j < L; j++)
                        if (PR[j]) s += longint'(coef[j]) * win(L - 1 + k - j);
                    p1d[k] = quant(s);
                end
                for (int m = 0; m < L - 1; m++) nh[m] = win(m + P);
                hx = nh;
            end
        end
    endtask

    task automatic set_smp(int a, int b, int c, int d);
        smp[0] = a; smp[1] = b; smp[2] = c; smp[3] = d;
    endtask

    task automatic rnd_smp();
        for (int k = 0; k < P; k++) smp[k] = int'(rnd() % 256) - 128;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int j = 0; j < L; j++) coef[j] = 0;
        for (int k = 0; k < P; k++) begin smp[k] = 0; held[k] = 0; p1d[k] = 0; p2d[k] = 0; end
        for (int m = 0; m < L - 1; m++) hx[m] = 0;

        // R8: reset state
        repeat (3) step(0, 0);

        // R1 R4: impulse at every lane position; pruned taps 1 and 6 carry nonzero garbage
        req = "R1 R4";
        coef = '{13, -7, 22, -31, 45, 9, 99, -64};
        for (int pos = 0; pos < P; pos++) begin
            set_smp(0, 0, 0, 0);
            smp[pos] = 64;
            step(1, 1);
            set_smp(0, 0, 0, 0);
            repeat (3) step(1, 1);
        end

        // R1 R3 R7 R9: random frames, gaps with garbage, coefficient reloads on frame cycles
        req = "R1 R3 R7 R9";
        for (int i = 0; i < 300; i++) begin
            if (i % 5 == 0)
                for (int j = 0; j < L; j++) coef[j] = int'(rnd() % 256) - 128;
            rnd_smp();
            step(1, (rnd() % 4) != 0);
        end
        repeat (2) step(1, 0);

        // R5: rounding of halves and near-halves through tap 0 alone
        req = "R5";
        coef = '{1, 0, 0, 0, 0, 0, 0, 0};
        set_smp(32, -32, 31, -33); step(1, 1);
        set_smp(33, -31, 96, -96); step(1, 1);
        set_smp(-64, 63, -95, 95); step(1, 1);
        repeat (2) step(1, 0);

        // R6: positive and negative saturation
        req = "R6";
        coef = '{127, 127, 127, 127, 127, 127, 127, 127};
        set_smp(127, 127, 127, 127); repeat (3) step(1, 1);
        set_smp(-128, -128, -128, -128); repeat (3) step(1, 1);
        coef = '{-128, -128, -128, -128, -128, -128, -128, -128};
        repeat (3) step(1, 1);
        repeat (2) step(1, 0);

        // R8: reset with a frame in flight and a frame offered during reset
        req = "R8";
        coef = '{5, 3, -9, 17, 2, -4, 6, 11};
        rnd_smp(); step(1, 1);
        rnd_smp(); step(0, 1);
        rnd_smp(); step(1, 1);
        rnd_smp(); step(1, 1);
        repeat (3) step(1, 0);

        finish_run();
    end
endmodule